// File: doc/BRIEF.md
# MII Ethernet Frame Transmitter

This block builds one fixed-length Ethernet frame each time it is started and drives it onto a 4-bit MII transmit bus. A frame opens with seven 0x55 preamble bytes and one 0xD5 start-of-frame delimiter. The 60 body bytes follow: destination, source, length, data and pad. The body comes from an external source that the block addresses by index, one byte every two clocks. The frame closes with a 4-byte frame check sequence.

The check value is a CRC-32 with generator 0x04C11DB7. It is worked out byte by byte while the body goes out. The FCS has no shift path of its own. Each FCS byte is taken from the complemented CRC remainder, its bits reversed, and handed to the same low-nibble-first path that carries every other byte. The result is that the remainder's x31 term is the first FCS bit on the wire.

Top module: `mii_frame_tx`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `mii_txen_o`, `mii_txd_o`, `done_o` and `byte_rd_o` are all zero.
- R2: Every byte is sent as two nibbles: bits 3:0 first, then bits 7:4. The frame begins with seven bytes of 0x55 and then one byte of 0xD5.
- R3: A start accepted in idle raises `mii_txen_o` on the next cycle. It then stays high for exactly 144 consecutive cycles (72 bytes) and drops.
- R4: After the delimiter, the 60 body bytes are sent in index order 0..59. In the cycle where `byte_rd_o` is high, `byte_i` is sampled as the byte numbered `byte_idx_o`. This pulse comes once per body byte, with indices rising from 0.
- R5: The last four bytes on the bus are the FCS. FCS byte k (k = 0..3) is the bit reversal of the complement of remainder bits [31-8k:24-8k]. The remainder is a CRC-32 (0x04C11DB7) preset to all ones and fed each body byte bit 0 first. As an example, a remainder of 0x58C52FE0 gives the bytes E5, 5C, 0B, F8.
- R6: A start pulse that arrives while a frame is in progress has no effect. This includes a pulse during the last nibble. The frame keeps its length and content, and no new frame follows it.
- R7: `done_o` is high for exactly the single cycle right after the last FCS nibble.
- R8: The CRC is preset again at every accepted start. A frame started in the `done_o` cycle of the previous frame therefore carries an FCS over its own body only.
- R9: Whenever `mii_txen_o` is low, `mii_txd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a frame when the block is idle |
| byte_i | input | 8 | Body byte for index `byte_idx_o` |
| byte_rd_o | output | 1 | `byte_i` is sampled this cycle |
| byte_idx_o | output | 6 | Index of the body byte being fetched |
| mii_txd_o | output | 4 | MII transmit nibble |
| mii_txen_o | output | 1 | MII transmit enable |
| done_o | output | 1 | One-cycle pulse after the last nibble |

## Verification
The bench aims at nibble order and the FCS bit order. A design that swaps the nibbles, or shifts the FCS MSB first, fails the preamble compare (0x55 read as 0x55 but 0xD5 as 0x5D) or every FCS byte. Start pulses are placed in the middle of a frame and on its last nibble. A block that restarts would show a wrong nibble count or a stray second frame. A start is also given in the `done_o` cycle. A CRC that is not preset again would leave that frame's FCS wrong while the data stayed right. The body uses all-zero, all-ones, counting and random patterns, so a missed or doubled CRC update is exposed.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  localparam int FCS_BYTES = 4;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_FCS
  } phase_t;

  // Fold one byte into the remainder, bit 0 of the byte first.
  function automatic logic [31:0] crc_byte(input logic [31:0] rem, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = rem;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [7:0] bitrev8(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = b[7-i];
    return o;
  endfunction

  // FCS byte k: complemented remainder byte, most significant first, bit-reversed.
  function automatic logic [7:0] fcs_byte(input logic [31:0] rem, input logic [1:0] k);
    logic [31:0] inv;
    logic [7:0]  sel;
    inv = ~rem;
    case (k)
      2'd0:    sel = inv[31:24];
      2'd1:    sel = inv[23:16];
      2'd2:    sel = inv[15:8];
      default: sel = inv[7:0];
    endcase
    return bitrev8(sel);
  endfunction

endpackage

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES  = 7,
  parameter int BODY_BYTES = 60,
  parameter int CNT_W      = 7,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output phase_t           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nib_o,
  output logic             frame_start_o,
  output logic             rd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             nib_q;
  logic             done_q;
  logic             last_byte;
  phase_t           phase_nx;

  assign frame_start_o = start_i && (phase_q == PH_IDLE);

  always_comb begin
    last_byte = 1'b0;
    phase_nx  = PH_IDLE;
    case (phase_q)
      PH_PRE:  begin last_byte = (cnt_q == CNT_W'(PRE_BYTES - 1));  phase_nx = PH_SFD;  end
      PH_SFD:  begin last_byte = 1'b1;                              phase_nx = PH_DATA; end
      PH_DATA: begin last_byte = (cnt_q == CNT_W'(BODY_BYTES - 1)); phase_nx = PH_FCS;  end
      PH_FCS:  begin last_byte = (cnt_q == CNT_W'(FCS_BYTES - 1));  phase_nx = PH_IDLE; end
      default: begin last_byte = 1'b0;                              phase_nx = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      nib_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_FCS) && nib_q && last_byte;
      if (frame_start_o) begin
        phase_q <= PH_PRE;
        cnt_q   <= '0;
        nib_q   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        nib_q <= ~nib_q;
        if (nib_q) begin
          if (last_byte) begin
            phase_q <= phase_nx;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign rd_o    = nib_q && ((phase_q == PH_SFD) || ((phase_q == PH_DATA) && !last_byte));
  assign idx_o   = (phase_q == PH_DATA) ? IDX_W'(cnt_q + 1'b1) : '0;
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign nib_o   = nib_q;
  assign done_o  = done_q;

endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [31:0] rem_o
);

  logic [31:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= CRC_PRESET;
    else if (init_i) rem_q <= CRC_PRESET;
    else if (upd_i)  rem_q <= crc_byte(rem_q, data_i);
  end

  assign rem_o = rem_q;

endmodule

// File: rtl/mii_tx_nib.sv
module mii_tx_nib
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase_i,
  input  logic [1:0]  fcs_sel_i,
  input  logic        nib_i,
  input  logic        rd_i,
  input  logic [7:0]  byte_i,
  input  logic [31:0] crc_rem_i,
  output logic [7:0]  data_o,
  output logic [3:0]  txd_o,
  output logic        txen_o
);

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  logic [7:0] data_q;
  logic [7:0] cur_byte;

  always_ff @(posedge clk) begin
    if (!rst_n)    data_q <= '0;
    else if (rd_i) data_q <= byte_i;
  end

  always_comb begin
    case (phase_i)
      PH_PRE:  cur_byte = PRE_BYTE;
      PH_SFD:  cur_byte = SFD_BYTE;
      PH_DATA: cur_byte = data_q;
      PH_FCS:  cur_byte = fcs_byte(crc_rem_i, fcs_sel_i);
      default: cur_byte = 8'h00;
    endcase
  end

  assign txen_o = (phase_i != PH_IDLE);
  assign txd_o  = !txen_o ? 4'h0 : (nib_i ? cur_byte[7:4] : cur_byte[3:0]);
  assign data_o = data_q;

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES  = 7,
  parameter int BODY_BYTES = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       byte_rd_o,
  output logic [5:0] byte_idx_o,
  output logic [3:0] mii_txd_o,
  output logic       mii_txen_o,
  output logic       done_o
);

  localparam int MAX_CNT = (BODY_BYTES > PRE_BYTES) ? BODY_BYTES : PRE_BYTES;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;
  localparam int IDX_W   = 6;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             nib;
  logic             frame_start;
  logic             crc_upd;
  logic [31:0]      crc_rem;
  logic [7:0]       data_q;

  mii_tx_seq #(
    .PRE_BYTES (PRE_BYTES),
    .BODY_BYTES(BODY_BYTES),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .phase_o      (phase),
    .cnt_o        (cnt),
    .nib_o        (nib),
    .frame_start_o(frame_start),
    .rd_o         (byte_rd_o),
    .idx_o        (byte_idx_o),
    .done_o       (done_o)
  );

  assign crc_upd = (phase == PH_DATA) && nib;

  mii_tx_crc crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .init_i(frame_start),
    .upd_i (crc_upd),
    .data_i(data_q),
    .rem_o (crc_rem)
  );

  mii_tx_nib nib_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .fcs_sel_i(cnt[1:0]),
    .nib_i    (nib),
    .rd_i     (byte_rd_o),
    .byte_i   (byte_i),
    .crc_rem_i(crc_rem),
    .data_o   (data_q),
    .txd_o    (mii_txd_o),
    .txen_o   (mii_txen_o)
  );

endmodule

// File: rtl/mii_frame_tx_chk.sv
module mii_frame_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txen,
  input logic [3:0]  txd,
  input logic        done,
  input logic        rd,
  input logic        frame_start,
  input logic [31:0] crc_rem
);

  // R9
  idle_txd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> (txd == 4'h0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txen && $past(txen)));

  // R4
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (txen && !done));

  // R4
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);

  // R6
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !txen);

  // R2
  first_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (txen && txd == 4'h5));

  // R8
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (crc_rem == 32'hFFFFFFFF));

endmodule

bind mii_frame_tx mii_frame_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .txen       (mii_txen_o),
  .txd        (mii_txd_o),
  .done       (done_o),
  .rd         (byte_rd_o),
  .frame_start(frame_start),
  .crc_rem    (crc_rem)
);

// File: tb/mii_frame_tx_tb_top.sv
module mii_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] byte_i;
  logic       byte_rd_o;
  logic [5:0] byte_idx_o;
  logic [3:0] mii_txd_o;
  logic       mii_txen_o;
  logic       done_o;

  logic [7:0] content [0:63];
  logic [7:0] got [0:127];
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign byte_i = content[byte_idx_o];

  mii_frame_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .byte_i    (byte_i),
    .byte_rd_o (byte_rd_o),
    .byte_idx_o(byte_idx_o),
    .mii_txd_o (mii_txd_o),
    .mii_txen_o(mii_txen_o),
    .done_o    (done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reflected-form CRC-32 over the 60 body bytes.
  function automatic logic [31:0] ref_crc();
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < 60; i++) begin
      r ^= {24'h0, content[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: content[i] = 8'h00;
        1: content[i] = 8'hFF;
        2: content[i] = 8'(i);
        default: content[i] = 8'($urandom);
      endcase
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Called at the negedge after the start edge; captures one frame.
  task automatic run_frame(input int glitch_at, input bit chain, input string fcs_req);
    int n = 0;
    int rdn = 0;
    bit idx_ok = 1'b1;
    bit ok;
    logic [3:0] lo = 4'h0;
    logic [31:0] inv;
    while (mii_txen_o && n < 400) begin
      if (n % 2 == 0) lo = mii_txd_o;
      else got[n/2] = {mii_txd_o, lo};
      if (byte_rd_o) begin
        if (byte_idx_o != 6'(rdn)) idx_ok = 1'b0;
        rdn++;
      end
      start_i = (n == glitch_at);
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == 144, "R3", "nibble count", n, 144);
    ok = 1'b1;
    for (int i = 0; i < 7; i++) if (got[i] != 8'h55) ok = 1'b0;
    check(ok, "R2", "preamble", got[0], 8'h55);
    check(got[7] == 8'hD5, "R2", "delimiter", got[7], 8'hD5);
    ok = 1'b1;
    for (int i = 0; i < 60; i++) if (got[8+i] != content[i]) ok = 1'b0;
    check(ok, "R4", "body bytes", got[8], content[0]);
    check(idx_ok && rdn == 60, "R4", "fetch count", rdn, 60);
    inv = ~ref_crc();
    check({got[71], got[70], got[69], got[68]} == inv, fcs_req, "fcs",
          {got[71], got[70], got[69], got[68]}, inv);
    check(done_o == 1'b1 && mii_txd_o == 4'h0, "R7", "done after last nibble", done_o, 1);
    check(mii_txd_o == 4'h0, "R9", "idle txd", mii_txd_o, 0);
    if (chain) begin
      pulse_start();
    end else begin
      @(negedge clk);
      check(done_o == 1'b0, "R7", "done width", done_o, 0);
      check(mii_txen_o == 1'b0, "R6", "no relaunch", mii_txen_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    fill(0);
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!mii_txen_o && mii_txd_o == 0 && !done_o && !byte_rd_o, "R1", "in reset",
          {mii_txen_o, mii_txd_o, done_o, byte_rd_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mii_txen_o && mii_txd_o == 0 && !done_o && !byte_rd_o, "R1", "idle after reset",
          {mii_txen_o, mii_txd_o, done_o, byte_rd_o}, 0);

    for (int k = 0; k < 6; k++) begin
      fill(k);
      pulse_start();
      run_frame(-1, 1'b0, "R5");
      repeat (2) @(negedge clk);
    end

    // R6: start mid-frame and on the last nibble
    fill(3);
    pulse_start();
    run_frame(41, 1'b0, "R6");
    fill(3);
    pulse_start();
    run_frame(143, 1'b0, "R6");

    // R8: back-to-back frames, second started in the done cycle
    fill(3);
    pulse_start();
    run_frame(-1, 1'b1, "R5");
    fill(2);
    run_frame(-1, 1'b0, "R8");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule